// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder with Toggle Status

This block is the device side of a 16-bit parallel NOR flash, written as a synthesizable behavioural target for system benches and emulation. It watches host write cycles for multi-cycle unlock scripts and decodes word program, sector erase, whole-array erase, identification entry and identification exit. The storage is a small register array whose depth and sector size are parameters. Program and erase time is modelled by a down-counter whose load value depends on the operation.

While an operation is running, any read returns a status word in which bit 6 flips on every read, and all other bits are zero. A host polls until two reads agree. Writes that arrive during that time are dropped. Outside busy time, reads return array contents, or identification codes while the identification mode is active. A write-protect input, active low, blocks whole-array erase.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset every array word reads 0xFFFF, the decoder is idle, identification mode is off, and `rdata` is updated on the clock edge that samples `rd_en`, so a read's value is seen one cycle after the request.
- R2: A program takes four writes: low byte 0xAA at address 0x5555, low byte 0x55 at 0x2AAA, low byte 0xA0 at 0x5555, then any address and the full 16-bit data. Only the low byte of the three command cycles is compared, and addresses are compared in full.
- R3: Programming stores the bitwise AND of the written data and the old word, so bits only move from 1 to 0.
- R4: Writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then low byte 0x30 at any address set every word of that address's sector (word index divided by SECTOR_WORDS) to 0xFFFF and leave other sectors unchanged.
- R5: The same five-write prefix followed by low byte 0x10 at 0x5555 sets every word to 0xFFFF, unless `wp_n` is low, in which case nothing happens and no busy period starts.
- R6: After a program, sector erase or whole-array erase is accepted, the next PROG_CYC, SERASE_CYC or CERASE_CYC cycles respectively are busy. A read sampled during busy returns a word whose only possibly set bit is bit 6, which is the inverse of the bit 6 of the previous status read. The first status read after reset has bit 6 set. After the busy period, reads return array data.
- R7: Every write during a busy period is ignored and leaves the decoder idle.
- R8: A write that does not match the next expected address and data of a script returns the decoder to idle, and that write is not taken as the first cycle of a new script.
- R9: After the prefix plus 0x90@0x5555, reads at address 0 return 0x00BF, at address 1 return DEV_CODE, and 0x0000 elsewhere. The prefix plus 0xF0@0x5555 returns to array reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| rd_en | input | 1 | Host read strobe, one cycle per bus read |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data |
| wp_n | input | 1 | Write protect, low blocks whole-array erase |
| rdata | output | 16 | Registered read data or status |

## Verification
The main function is driven with a clean program script, a script whose command bytes carry non-zero upper bytes, and a second program onto an already programmed word. Together these separate full-word matching from low-byte matching, and a plain store from AND-merging. The decoder's abort is tried with a wrong address on the second cycle and with a repeated first cycle. The repeated first cycle tells apart a tracker that re-reads the faulting write from one that drops it. Back-to-back reads right after a program pin down the exact busy length and the flip of bit 6. Erase scripts are run with and without write protect and with a wrong sixth byte, and word 0 is programmed before identification mode so that the identification codes cannot be confused with array data.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_UNL1,
      SQ_UNL2,
      SQ_ARM,
      SQ_ERA1,
      SQ_ERA2,
      SQ_PROG
   } seq_state_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_PROG    = 8'hA0;
   localparam logic [7:0] OP_ARM     = 8'h80;
   localparam logic [7:0] OP_SECTOR  = 8'h30;
   localparam logic [7:0] OP_WHOLE   = 8'h10;
   localparam logic [7:0] OP_ID_IN   = 8'h90;
   localparam logic [7:0] OP_ID_OUT  = 8'hF0;

   localparam int unsigned UNLOCK_ADDR_A = 32'h5555;
   localparam int unsigned UNLOCK_ADDR_B = 32'h2AAA;

   localparam logic [15:0] VENDOR_WORD = 16'h00BF;
endpackage

// File: rtl/nor_seq_tracker.sv
module nor_seq_tracker
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        key,
   input  logic              busy,
   input  logic              wp_n,
   output logic              prog_go,
   output logic              sect_go,
   output logic              whole_go,
   output logic              id_mode
);
   localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
   localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

   seq_state_e st, st_nxt;
   logic       id_set, id_clr;
   logic       at_a, at_b;

   assign at_a = (addr == ADDR_A);
   assign at_b = (addr == ADDR_B);

   always_comb begin
      st_nxt   = st;
      prog_go  = 1'b0;
      sect_go  = 1'b0;
      whole_go = 1'b0;
      id_set   = 1'b0;
      id_clr   = 1'b0;
      if (wr_en) begin
         if (busy) begin
            st_nxt = SQ_IDLE;
         end else begin
            case (st)
               SQ_IDLE: st_nxt = (at_a && key == KEY_FIRST)  ? SQ_UNL1 : SQ_IDLE;
               SQ_UNL1: st_nxt = (at_b && key == KEY_SECOND) ? SQ_UNL2 : SQ_IDLE;
               SQ_UNL2: begin
                  st_nxt = SQ_IDLE;
                  if (at_a) begin
                     case (key)
                        OP_PROG:   st_nxt = SQ_PROG;
                        OP_ARM:    st_nxt = SQ_ARM;
                        OP_ID_IN:  id_set = 1'b1;
                        OP_ID_OUT: id_clr = 1'b1;
                        default:   st_nxt = SQ_IDLE;
                     endcase
                  end
               end
               SQ_ARM:  st_nxt = (at_a && key == KEY_FIRST)  ? SQ_ERA1 : SQ_IDLE;
               SQ_ERA1: st_nxt = (at_b && key == KEY_SECOND) ? SQ_ERA2 : SQ_IDLE;
               SQ_ERA2: begin
                  st_nxt = SQ_IDLE;
                  if (key == OP_SECTOR)
                     sect_go = 1'b1;
                  else if (at_a && key == OP_WHOLE && wp_n)
                     whole_go = 1'b1;
               end
               SQ_PROG: begin
                  st_nxt  = SQ_IDLE;
                  prog_go = 1'b1;
               end
               default: st_nxt = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         id_mode <= 1'b0;
      end else begin
         st <= st_nxt;
         if (id_set)
            id_mode <= 1'b1;
         else if (id_clr)
            id_mode <= 1'b0;
      end
   end

   // R7: a write during busy leaves the tracker idle
   assert_busy_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (st == SQ_IDLE));

   // R8: a mismatching second cycle aborts the script
   assert_abort_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && st == SQ_UNL1 && !(at_b && key == KEY_SECOND)) |=> (st == SQ_IDLE));

   // R4/R5/R2: at most one operation starts per cycle
   assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_go, sect_go, whole_go}));
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
   parameter int PROG_CYC   = 8,
   parameter int SERASE_CYC = 24,
   parameter int CERASE_CYC = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_go,
   input  logic sect_go,
   input  logic whole_go,
   input  logic rd_en,
   output logic busy,
   output logic status_dq6
);
   localparam int MAX_A  = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
   localparam int MAX_C  = (MAX_A > CERASE_CYC) ? MAX_A : CERASE_CYC;
   localparam int CNT_W  = $clog2(MAX_C + 1);

   generate
      if (PROG_CYC < 1 || SERASE_CYC < 1 || CERASE_CYC < 1) begin : g_bad_time
         $error("busy durations must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             tog;
   logic             any_go;

   assign any_go     = prog_go | sect_go | whole_go;
   assign busy       = (cnt != '0);
   assign status_dq6 = ~tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (prog_go) begin
         cnt <= CNT_W'(PROG_CYC);
      end else if (sect_go) begin
         cnt <= CNT_W'(SERASE_CYC);
      end else if (whole_go) begin
         cnt <= CNT_W'(CERASE_CYC);
      end else if (busy) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog <= 1'b0;
      else if (rd_en && busy)
         tog <= ~tog;
   end

   // R6: an accepted operation makes the block busy next cycle
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (any_go && !busy) |=> busy);

   // R6: busy never rises without a start
   assert_no_spurious_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !any_go) |=> !busy);

   // R6: each status read flips the toggle state
   assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (tog != $past(tog)));
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
   parameter int DEPTH        = 64,
   parameter int SECTOR_WORDS = 16,
   localparam int IDX_W       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog_go,
   input  logic             sect_go,
   input  logic             whole_go,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      wdata,
   output logic [15:0]      rd_word
);
   localparam int SEC_SHIFT = $clog2(SECTOR_WORDS);

   generate
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if ((1 << SEC_SHIFT) != SECTOR_WORDS || SECTOR_WORDS > DEPTH) begin : g_bad_sector
         $error("SECTOR_WORDS must be a power of two no larger than DEPTH");
      end
   endgenerate

   logic [15:0] mem [DEPTH];

   assign rd_word = mem[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (whole_go)
               mem[i] <= '1;
            else if (sect_go && ((IDX_W'(i) >> SEC_SHIFT) == (idx >> SEC_SHIFT)))
               mem[i] <= '1;
            else if (prog_go && IDX_W'(i) == idx)
               mem[i] <= mem[i] & wdata;
         end
      end
   end

   // R3: program merges new data with old contents by AND
   assert_prog_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |=> (mem[$past(idx)] == ($past(rd_word) & $past(wdata))));

   // R5: whole-array erase leaves the end words erased
   assert_whole_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      whole_go |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
   import nor_cmd_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          DEPTH        = 64,
   parameter int          SECTOR_WORDS = 16,
   parameter int          PROG_CYC     = 8,
   parameter int          SERASE_CYC   = 24,
   parameter int          CERASE_CYC   = 48,
   parameter logic [15:0] DEV_CODE     = 16'h2A5C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              wp_n,
   output logic [15:0]       rdata
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (ADDR_W < 15 || ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must reach the unlock addresses and exceed the array index");
      end
   endgenerate

   logic        prog_go, sect_go, whole_go;
   logic        id_mode, busy, status_dq6;
   logic [15:0] arr_word, id_word, status_word;

   nor_seq_tracker #(.ADDR_W(ADDR_W)) u_tracker (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .key      (wdata[7:0]),
      .busy     (busy),
      .wp_n     (wp_n),
      .prog_go  (prog_go),
      .sect_go  (sect_go),
      .whole_go (whole_go),
      .id_mode  (id_mode)
   );

   nor_busy_timer #(
      .PROG_CYC   (PROG_CYC),
      .SERASE_CYC (SERASE_CYC),
      .CERASE_CYC (CERASE_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_go    (prog_go),
      .sect_go    (sect_go),
      .whole_go   (whole_go),
      .rd_en      (rd_en),
      .busy       (busy),
      .status_dq6 (status_dq6)
   );

   nor_word_array #(
      .DEPTH        (DEPTH),
      .SECTOR_WORDS (SECTOR_WORDS)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_go  (prog_go),
      .sect_go  (sect_go),
      .whole_go (whole_go),
      .idx      (addr[IDX_W-1:0]),
      .wdata    (wdata),
      .rd_word  (arr_word)
   );

   always_comb begin
      if (addr == ADDR_W'(0))
         id_word = VENDOR_WORD;
      else if (addr == ADDR_W'(1))
         id_word = DEV_CODE;
      else
         id_word = '0;
   end

   assign status_word = {9'b0, status_dq6, 6'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= busy ? status_word : (id_mode ? id_word : arr_word);
   end

   // R6: a status read carries nothing but bit 6
   assert_status_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (rdata[15:7] == '0 && rdata[5:0] == '0));
endmodule

// File: tb/nor_cmd_engine_bench.sv
`timescale 1ns/1ps
module nor_cmd_engine_bench;
   localparam int          PROG_N = 8;
   localparam int          SECT_N = 24;
   localparam int          CHIP_N = 48;
   localparam logic [15:0] DEV    = 16'h2A5C;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en, wp_n;
   logic [15:0] addr, wdata;
   logic [15:0] rdata;

   always #10 clk = ~clk;

   nor_cmd_engine u_nor_cmd_engine (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .wp_n  (wp_n),
      .rdata (rdata)
   );

   logic [15:0] model [64];
   bit          tog_m = 1'b0;
   logic [15:0] exp_q [$];
   string       tag_q [$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic        rd_pend = 1'b0;
   bit          done = 1'b0;

   always @(posedge clk) rd_pend <= rd_en;

   // monitor: compares each read result against the scoreboard
   always @(negedge clk) begin
      if (rd_pend) begin
         logic [15:0] e;
         string       t;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read: got %h expected none", rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_arr(input logic [15:0] a, input string t);
      rd(a, model[a[5:0]], t);
   endtask

   task automatic rd_stat(input logic [15:0] a, input string t);
      tog_m = ~tog_m;
      rd(a, {9'b0, tog_m, 6'b0}, t);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock();
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0055);
   endtask

   task automatic prog(input logic [15:0] a, input logic [15:0] d);
      unlock();
      wr(16'h5555, 16'h00A0);
      wr(a, d);
      model[a[5:0]] = model[a[5:0]] & d;
   endtask

   task automatic sect(input logic [15:0] a);
      unlock();
      wr(16'h5555, 16'h0080);
      unlock();
      wr(a, 16'h0030);
      for (int i = 0; i < 64; i++)
         if ((i >> 4) == (a[5:0] >> 4)) model[i] = 16'hFFFF;
   endtask

   task automatic whole();
      unlock();
      wr(16'h5555, 16'h0080);
      unlock();
      wr(16'h5555, 16'h0010);
      if (wp_n)
         for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wp_n = 1'b1;
      addr = '0; wdata = '0;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1: erased array after reset
      rd_arr(16'd0,  "R1 reset word 0");
      rd_arr(16'd63, "R1 reset word 63");

      // R2 + R6: program, then back-to-back reads pin the busy length
      prog(16'd3, 16'h1234);
      for (int k = 0; k < PROG_N; k++) rd_stat(16'd3, "R6 program status");
      rd_arr(16'd3, "R2 program result after busy");

      // R3: AND merge
      prog(16'd3, 16'hFF0F);
      idle(PROG_N + 2);
      rd_arr(16'd3, "R3 AND merge");

      // R2: only low bytes of command cycles compared
      wr(16'h5555, 16'h12AA);
      wr(16'h2AAA, 16'hFF55);
      wr(16'h5555, 16'h77A0);
      wr(16'd7, 16'h00F0);
      model[7] = model[7] & 16'h00F0;
      idle(PROG_N + 2);
      rd_arr(16'd7, "R2 upper byte ignored");

      // R8: wrong second address aborts
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAB, 16'h0055);
      wr(16'h5555, 16'h00A0);
      wr(16'd5, 16'h0000);
      rd_arr(16'd5, "R8 wrong address abort");

      // R8: repeated first cycle is not restarted
      wr(16'h5555, 16'h00AA);
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0055);
      wr(16'h5555, 16'h00A0);
      wr(16'd6, 16'h0000);
      rd_arr(16'd6, "R8 faulting write not reinterpreted");

      // R7: full program script during busy is dropped
      prog(16'd10, 16'h00FF);
      unlock();
      wr(16'h5555, 16'h00A0);
      wr(16'd11, 16'h0000);
      idle(PROG_N + 2);
      rd_arr(16'd10, "R7 first program kept");
      rd_arr(16'd11, "R7 program during busy ignored");

      // R4: sector erase
      prog(16'd17, 16'h0000);
      idle(PROG_N + 2);
      prog(16'd33, 16'h0000);
      idle(PROG_N + 2);
      sect(16'd20);
      rd_stat(16'd20, "R4 sector erase busy");
      idle(SECT_N + 2);
      rd_arr(16'd17, "R4 sector word erased");
      rd_arr(16'd33, "R4 other sector kept");
      rd_arr(16'd3,  "R4 sector 0 kept");

      // R8: wrong sixth byte
      unlock();
      wr(16'h5555, 16'h0080);
      unlock();
      wr(16'd33, 16'h0050);
      rd_arr(16'd33, "R8 wrong sixth byte");

      // R5: protected whole erase ignored
      wp_n = 1'b0;
      whole();
      rd_arr(16'd33, "R5 protected erase ignored");
      wp_n = 1'b1;
      whole();
      rd_stat(16'd0, "R5 whole erase busy");
      rd_stat(16'd0, "R6 toggle flips again");
      idle(CHIP_N + 2);
      rd_arr(16'd33, "R5 whole erase word 33");
      rd_arr(16'd3,  "R5 whole erase word 3");

      // R9: identification mode
      prog(16'd0, 16'h5A5A);
      idle(PROG_N + 2);
      rd_arr(16'd0, "R9 word 0 before entry");
      unlock();
      wr(16'h5555, 16'h0090);
      rd(16'd0, 16'h00BF, "R9 vendor code");
      rd(16'd1, DEV,      "R9 device code");
      rd(16'd2, 16'h0000, "R9 other address");
      unlock();
      wr(16'h5555, 16'h00F0);
      rd_arr(16'd0, "R9 exit to array");

      idle(3);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard drain: got %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      report();
      $finish;
   end
endmodule